// File: doc/BRIEF.md
# Double-Buffered DMA Channel Controller

A single DMA channel that moves beats of 8, 16 or 32 bits between a peripheral FIFO and memory. Software programs it through a small 32-bit register window: a control/status word that can be changed only through a bit-set alias and a bit-clear alias, the peripheral FIFO address, and two buffer descriptors. Each descriptor holds a memory start address and a 16-bit beat count. The channel drains the active buffer one beat per peripheral request. When the count of the active buffer reaches zero it flags that buffer as finished and swaps to the other buffer. Software refills the idle buffer while the other one runs, so a stream can continue without a gap.

Each beat is offered on the memory port and on the device port at the same time, with one shared valid. The beat completes in the first cycle in which both ready inputs are high. The direction bit picks which side supplies the data. The endianness bit reverses byte lanes inside the beat width. Clearing the go bit is a stop request: any beat already offered is finished first, and the halted status bit then reports that the channel is quiet.

The sequencer has five states:
- **ST_HALT**: stopped. It leaves for ST_IDLE when go is 1.
- **ST_IDLE**: go is 1 and no beat is pending. It goes to ST_HALT if go is 0. If the active buffer is enabled it goes to ST_DONE when the count is 0, otherwise to ST_WAIT.
- **ST_WAIT**: armed. It goes to ST_HALT if go is 0, back to ST_IDLE if the active buffer lost its enable or its count, and to ST_BEAT on a peripheral request.
- **ST_BEAT**: the beat is offered. On the handshake it goes to ST_DONE if this was the last beat, otherwise to ST_HALT if go is 0, otherwise to ST_WAIT.
- **ST_DONE**: lasts one cycle. It marks the buffer finished, swaps the active buffer and returns to ST_IDLE.

Top module: `dbdma_channel`

## Requirements
- R1: After reset the control word reads 0x0000_0040 (only halted set), all descriptor and peripheral-address registers read 0, irq is 0 and mem_valid is 0.
- R2: The register window uses the byte offset on reg_addr:
  - 0x00: bit-set alias for the control word; a read returns the control word.
  - 0x04: bit-clear alias for the control word; a read returns 0.
  - 0x08: peripheral FIFO address.
  - 0x0C / 0x10: buffer 0 start / count.
  - 0x14 / 0x18: buffer 1 start / count.

  The control word bits are:
  - bit 0: buffer 0 enable; bit 1: buffer 0 done.
  - bit 2: buffer 1 enable; bit 3: buffer 1 done.
  - bit 4: active buffer; bit 5: go; bit 6: halted.
  - bit 7: irq enable; bit 8: non-coherent.
  - bits 10:9: width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit).
  - bit 11: size-8 flag; bit 12: direction; bit 13: endianness.
  - bit 15: bank select; bits 19:16: device number.

  The set alias cannot set bits 1, 3 or 6. Bit 14 and bits 31:20 always read 0.
- R3: A count register keeps only bits 15:0 of a write. The start and peripheral-address registers keep all 32 bits.
- R4: With go = 1, the active buffer enabled and its count nonzero, dev_req starts a beat. mem_valid and dev_valid rise, mem_addr is the active start register, dev_addr is the peripheral address and mem_size is the width field. The beat is held unchanged until mem_ready and dev_ready are both 1. No beat starts while dev_req is 0.
- R5: Each completed beat lowers the active count by 1 and raises the active start address by 1, 2 or 4 bytes for width 0, 1 or 2 (width 3 steps by 4).
- R6: When the active count reaches 0 the channel does three things: it sets that buffer's done bit, clears its enable bit and toggles the active bit. It then continues with the other buffer if that one is enabled. Otherwise it idles with go still 1 and halted 0. An enabled buffer whose count is already 0 completes without any beat.
- R7: A done bit stays set until a 1 is written to it through offset 0x04.
- R8: irq is 1 exactly when irq enable is 1 and at least one done bit is 1.
- R9: After go is cleared with no beat offered, halted reads 1 within 2 cycles. If a beat is offered, halted stays 0 and the beat stays offered until its handshake; after that no new beat starts and halted becomes 1. Halted reads 0 from the cycle after go is written to 1.
- R10: Direction 0 moves data from the device to memory: mem_we = 1, dev_we = 0, mem_wdata is taken from dev_rdata and dev_wdata = 0. Direction 1 reverses this: dev_wdata is taken from mem_rdata and mem_wdata = 0.
- R11: With endianness 1, the moved data is byte-reordered within the beat width:
  - width 2 or 3: all four bytes are reversed.
  - width 1: bytes 0 and 1 are swapped and bytes 3:2 pass unchanged.
  - width 0: the data is unchanged.

  With endianness 0 the data is never changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Byte offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dev_req | input | 1 | Peripheral beat request |
| mem_valid | output | 1 | Beat offered to memory |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | AW | Memory byte address of the beat |
| mem_size | output | 2 | Beat width code |
| mem_we | output | 1 | 1 when the beat writes memory |
| mem_wdata | output | 32 | Data written to memory |
| mem_rdata | input | 32 | Data read from memory |
| dev_valid | output | 1 | Beat offered to the peripheral FIFO |
| dev_ready | input | 1 | Peripheral accepts the beat |
| dev_addr | output | AW | Peripheral FIFO address |
| dev_we | output | 1 | 1 when the beat writes the peripheral |
| dev_wdata | output | 32 | Data written to the peripheral |
| dev_rdata | input | 32 | Data read from the peripheral |
| irq | output | 1 | Buffer-done interrupt |

## Verification
The properties assume that software does not rewrite a start or count register, or the active bit, while a beat is offered or a buffer is completing. A write of that kind would legitimately move mem_addr or the counts under the handshake. The bench therefore programs descriptors only while the channel is halted. During a held beat it changes only the width, direction and endianness bits, which none of the properties observe. The ready inputs are driven freely, so beats can be held for many cycles. This lets the stop request be tested against a beat in flight.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

    // word index (byte offset / 4) of each register
    localparam int W_MSET = 0;
    localparam int W_MCLR = 1;
    localparam int W_PADR = 2;
    localparam int W_B0ST = 3;
    localparam int W_B0CT = 4;
    localparam int W_B1ST = 5;
    localparam int W_B1CT = 6;

    // control word bit positions
    localparam int B_EN0 = 0;
    localparam int B_DN0 = 1;
    localparam int B_EN1 = 2;
    localparam int B_DN1 = 3;
    localparam int B_ACT = 4;
    localparam int B_GO  = 5;
    localparam int B_HLT = 6;
    localparam int B_IE  = 7;
    localparam int B_WLO = 9;
    localparam int B_WHI = 10;
    localparam int B_DIR = 12;
    localparam int B_END = 13;

    localparam logic [31:0] SET_MASK = 32'h000F_BFB5;
    localparam logic [31:0] CLR_MASK = 32'h000F_BFBF;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_IDLE,
        ST_WAIT,
        ST_BEAT,
        ST_DONE
    } eng_state_t;

    function automatic logic [2:0] beat_bytes(input logic [1:0] w);
        if (w == 2'd0)      return 3'd1;
        else if (w == 2'd1) return 3'd2;
        else                return 3'd4;
    endfunction

endpackage

// File: rtl/dbdma_regs.sv
module dbdma_regs
    import dbdma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RAW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic          beat,
    input  logic          finish,
    input  logic          halted,
    output logic [31:0]   mode_o,
    output logic [AW-1:0] act_addr,
    output logic [CW-1:0] act_cnt,
    output logic          act_en,
    output logic [AW-1:0] per_addr
);
    localparam int IW   = RAW - 2;
    localparam int NBUF = 2;

    logic [IW-1:0] idx;
    logic [31:0]   mode_q, mode_d;
    logic [AW-1:0] pa_q;
    logic [AW-1:0] start_w [NBUF];
    logic [CW-1:0] cnt_w   [NBUF];
    logic          ab;
    logic [AW-1:0] step;

    assign idx  = addr[RAW-1:2];
    assign ab   = mode_q[B_ACT];
    assign step = AW'(beat_bytes(mode_q[B_WHI:B_WLO]));

    // control word: software set/clear first, completion event wins
    always_comb begin
        mode_d = mode_q;
        if (wr_en && idx == IW'(W_MSET)) mode_d = mode_d | (wdata & SET_MASK);
        if (wr_en && idx == IW'(W_MCLR)) mode_d = mode_d & ~(wdata & CLR_MASK);
        if (finish) begin
            mode_d[ab ? B_DN1 : B_DN0] = 1'b1;
            mode_d[ab ? B_EN1 : B_EN0] = 1'b0;
            mode_d[B_ACT]              = ~mode_q[B_ACT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pa_q <= '0;
        else if (wr_en && idx == IW'(W_PADR)) pa_q <= AW'(wdata);
    end

    // one descriptor per buffer
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        localparam logic [IW-1:0] ST_IDX = IW'(W_B0ST + 2 * b);
        localparam logic [IW-1:0] CT_IDX = IW'(W_B0CT + 2 * b);
        logic [AW-1:0] st_q;
        logic [CW-1:0] ct_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
                ct_q <= '0;
            end else begin
                if (beat && int'(ab) == b) begin
                    st_q <= st_q + step;
                    ct_q <= ct_q - CW'(1);
                end
                if (wr_en && idx == ST_IDX) st_q <= AW'(wdata);
                if (wr_en && idx == CT_IDX) ct_q <= wdata[CW-1:0];
            end
        end

        assign start_w[b] = st_q;
        assign cnt_w[b]   = ct_q;
    end

    always_comb begin
        rdata = '0;
        case (idx)
            IW'(W_MSET): rdata = mode_q | (32'(halted) << B_HLT);
            IW'(W_PADR): rdata = 32'(pa_q);
            IW'(W_B0ST): rdata = 32'(start_w[0]);
            IW'(W_B0CT): rdata = 32'(cnt_w[0]);
            IW'(W_B1ST): rdata = 32'(start_w[1]);
            IW'(W_B1CT): rdata = 32'(cnt_w[1]);
            default:     rdata = '0;
        endcase
    end

    assign mode_o   = mode_q;
    assign act_addr = start_w[ab];
    assign act_cnt  = cnt_w[ab];
    assign act_en   = ab ? mode_q[B_EN1] : mode_q[B_EN0];
    assign per_addr = pa_q;

endmodule

// File: rtl/dbdma_engine.sv
module dbdma_engine
    import dbdma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          act_en,
    input  logic [CW-1:0] act_cnt,
    input  logic          dev_req,
    input  logic          mem_ready,
    input  logic          dev_ready,
    output logic          xfer_valid,
    output logic          beat,
    output logic          finish,
    output logic          halted
);
    eng_state_t state_q, state_d;
    logic       hs;

    assign hs = mem_ready && dev_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (go) state_d = ST_IDLE;
            ST_IDLE: begin
                if (!go)                state_d = ST_HALT;
                else if (act_en)        state_d = (act_cnt == '0) ? ST_DONE : ST_WAIT;
            end
            ST_WAIT: begin
                if (!go)                                state_d = ST_HALT;
                else if (!act_en || act_cnt == '0)      state_d = ST_IDLE;
                else if (dev_req)                       state_d = ST_BEAT;
            end
            ST_BEAT: begin
                if (hs) begin
                    if (act_cnt == CW'(1)) state_d = ST_DONE;
                    else if (!go)          state_d = ST_HALT;
                    else                   state_d = ST_WAIT;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        xfer_valid = (state_q == ST_BEAT);
        beat       = (state_q == ST_BEAT) && hs;
        finish     = (state_q == ST_DONE);
        halted     = (state_q == ST_HALT) && !go;
    end

endmodule

// File: rtl/dbdma_lanes.sv
module dbdma_lanes #(
    parameter int DW = 32
) (
    input  logic          dir,
    input  logic          endian,
    input  logic [1:0]    width,
    input  logic [DW-1:0] dev_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] dev_wdata,
    output logic          mem_we,
    output logic          dev_we
);
    localparam int NB = DW / 8;

    logic [DW-1:0] src, moved;

    always_comb begin
        src   = dir ? mem_rdata : dev_rdata;
        moved = src;
        if (endian) begin
            case (width)
                2'd1: moved[15:0] = {src[7:0], src[15:8]};
                2'd2, 2'd3: begin
                    for (int i = 0; i < NB; i++)
                        moved[8*i +: 8] = src[8*(NB-1-i) +: 8];
                end
                default: moved = src;
            endcase
        end
        mem_wdata = dir ? '0 : moved;
        dev_wdata = dir ? moved : '0;
        mem_we    = ~dir;
        dev_we    = dir;
    end

endmodule

// File: rtl/dbdma_channel.sv
module dbdma_channel
    import dbdma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           dev_req,
    output logic           mem_valid,
    input  logic           mem_ready,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic           mem_we,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    output logic           dev_valid,
    input  logic           dev_ready,
    output logic [AW-1:0]  dev_addr,
    output logic           dev_we,
    output logic [31:0]    dev_wdata,
    input  logic [31:0]    dev_rdata,
    output logic           irq
);
    logic [31:0]   mode_w;
    logic [AW-1:0] act_addr_w;
    logic [CW-1:0] act_cnt_w;
    logic          act_en_w;
    logic          go_w, ab_w;
    logic          beat_w, finish_w, halted_w, xfer_w;

    assign go_w = mode_w[B_GO];
    assign ab_w = mode_w[B_ACT];

    dbdma_regs #(.AW(AW), .CW(CW), .RAW(RAW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .beat     (beat_w),
        .finish   (finish_w),
        .halted   (halted_w),
        .mode_o   (mode_w),
        .act_addr (act_addr_w),
        .act_cnt  (act_cnt_w),
        .act_en   (act_en_w),
        .per_addr (dev_addr)
    );

    dbdma_engine #(.CW(CW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go_w),
        .act_en     (act_en_w),
        .act_cnt    (act_cnt_w),
        .dev_req    (dev_req),
        .mem_ready  (mem_ready),
        .dev_ready  (dev_ready),
        .xfer_valid (xfer_w),
        .beat       (beat_w),
        .finish     (finish_w),
        .halted     (halted_w)
    );

    dbdma_lanes #(.DW(32)) u_lanes (
        .dir       (mode_w[B_DIR]),
        .endian    (mode_w[B_END]),
        .width     (mode_w[B_WHI:B_WLO]),
        .dev_rdata (dev_rdata),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .dev_wdata (dev_wdata),
        .mem_we    (mem_we),
        .dev_we    (dev_we)
    );

    assign mem_valid = xfer_w;
    assign dev_valid = xfer_w;
    assign mem_addr  = act_addr_w;
    assign mem_size  = mode_w[B_WHI:B_WLO];
    assign irq       = mode_w[B_IE] & (mode_w[B_DN0] | mode_w[B_DN1]);

endmodule

// File: rtl/dbdma_channel_chk.sv
module dbdma_channel_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          dev_ready,
    input logic [AW-1:0] mem_addr,
    input logic          go,
    input logic          ab,
    input logic [CW-1:0] act_cnt,
    input logic          beat,
    input logic          finish,
    input logic          halted
);
    // R4: an offered beat stays offered, at the same address, until the handshake
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !(mem_ready && dev_ready) |=> mem_valid && $stable(mem_addr));

    // R4: no new beat appears while go is low
    p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !go && !mem_valid |=> !mem_valid);

    // R5: each completed beat lowers the active count by one
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> act_cnt == $past(act_cnt) - CW'(1));

    // R6: buffer completion swaps the active buffer
    p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> ab != $past(ab));

    // R9: a halted channel offers nothing
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_valid);

    // R9: stop request with nothing in flight halts in the next cycle
    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) && !mem_valid && !finish |=> halted);

endmodule

bind dbdma_channel dbdma_channel_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .dev_ready (dev_ready),
    .mem_addr  (mem_addr),
    .go        (go_w),
    .ab        (ab_w),
    .act_cnt   (act_cnt_w),
    .beat      (beat_w),
    .finish    (finish_w),
    .halted    (halted_w)
);

// File: tb/tb_dbdma_channel.sv
`timescale 1ns/1ps
module tb_dbdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_req = 1'b0;
    logic        mem_valid, mem_we, dev_valid, dev_we, irq;
    logic        mem_ready = 1'b1, dev_ready = 1'b1;
    logic [31:0] mem_addr, dev_addr, mem_wdata, dev_wdata;
    logic [31:0] mem_rdata = '0, dev_rdata = '0;
    logic [1:0]  mem_size;

    int nchk = 0, nfail = 0, nlog = 0;
    logic [31:0] log_addr [16];
    logic [1:0]  log_size [16];
    logic [31:0] log_dev  [16];
    bit done_flag = 0;

    always #5 clk = ~clk;

    dbdma_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dev_valid(dev_valid), .dev_ready(dev_ready),
        .dev_addr(dev_addr), .dev_we(dev_we), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .irq(irq)
    );

    // beat log, sampled with the values the design sees at the edge
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready && dev_ready) begin
            if (nlog < 16) begin
                log_addr[nlog] = mem_addr;
                log_size[nlog] = mem_size;
                log_dev[nlog]  = dev_addr;
            end
            nlog++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_mv();
        for (int i = 0; i < 50 && !mem_valid; i++) @(negedge clk);
        chk("R4 beat offered", 32'(mem_valid), 32'd1);
    endtask

    task automatic stop_and_clear();
        wr(5'h04, 32'h0000_0020);
        idle(3);
        wr(5'h04, 32'h000F_BFBF);
        nlog = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(5'h00, d); chk("R1 mode after reset", d, 32'h0000_0040);
        rd(5'h10, d); chk("R1 count0 after reset", d, 32'h0);
        rd(5'h08, d); chk("R1 fifo addr after reset", d, 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 no beat after reset", 32'(mem_valid), 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(5'h10, 32'h0001_2345); rd(5'h10, d); chk("R3 count masked", d, 32'h0000_2345);
        wr(5'h14, 32'hDEAD_BEEF); rd(5'h14, d); chk("R3 start1 full width", d, 32'hDEAD_BEEF);
        wr(5'h08, 32'h8000_0F00); rd(5'h08, d); chk("R3 fifo addr", d, 32'h8000_0F00);
        wr(5'h00, 32'hFFFF_FFDF); rd(5'h00, d); chk("R2 set alias mask", d, 32'h000F_BFD5);
        rd(5'h04, d); chk("R2 clear alias reads 0", d, 32'h0);
        wr(5'h04, 32'hFFFF_FFFF); rd(5'h00, d); chk("R2 clear alias", d, 32'h0000_0040);
        wr(5'h10, 32'h0); wr(5'h14, 32'h0);
    endtask

    task automatic t_single32();
        logic [31:0] d;
        nlog = 0;
        wr(5'h0C, 32'h1000); wr(5'h10, 32'd3); wr(5'h08, 32'h0000_0F00);
        wr(5'h00, 32'h0000_0481);
        dev_req = 1'b1; mem_ready = 1'b1; dev_ready = 1'b1;
        wr(5'h00, 32'h0000_0020);
        rd(5'h00, d); chk("R9 halted clears after go", d & 32'h40, 32'h0);
        idle(30);
        chk("R5 beat count", 32'(nlog), 32'd3);
        chk("R4 first addr", log_addr[0], 32'h1000);
        chk("R5 addr step 4 (b1)", log_addr[1], 32'h1004);
        chk("R5 addr step 4 (b2)", log_addr[2], 32'h1008);
        chk("R4 size field", 32'(log_size[0]), 32'd2);
        chk("R4 fifo addr on beat", log_dev[0], 32'h0F00);
        rd(5'h10, d); chk("R5 count drained", d, 32'h0);
        rd(5'h0C, d); chk("R5 start advanced", d, 32'h100C);
        rd(5'h00, d); chk("R6 done0 en0 cleared act toggled go kept", d & 32'h7F, 32'h0000_0032);
        chk("R6 idle no beat", 32'(mem_valid), 32'd0);
        chk("R8 irq with ie and done", 32'(irq), 32'd1);
        idle(5);
        rd(5'h00, d); chk("R7 done persists", d & 32'h2, 32'h2);
        wr(5'h04, 32'h0000_0002);
        #1 chk("R8 irq drops after clear", 32'(irq), 32'd0);
        rd(5'h00, d); chk("R7 done cleared via alias", d & 32'h2, 32'h0);
        dev_req = 1'b0;
        stop_and_clear();
    endtask

    task automatic t_pingpong16();
        logic [31:0] d;
        wr(5'h0C, 32'h2000); wr(5'h10, 32'd2);
        wr(5'h14, 32'h3000); wr(5'h18, 32'd2);
        wr(5'h00, 32'h0000_0205);
        dev_req = 1'b1;
        wr(5'h00, 32'h0000_0020);
        idle(40);
        chk("R6 pingpong beats", 32'(nlog), 32'd4);
        chk("R5 b0 addr", log_addr[0], 32'h2000);
        chk("R5 step 2", log_addr[1], 32'h2002);
        chk("R6 switch to buffer1", log_addr[2], 32'h3000);
        chk("R5 b1 step 2", log_addr[3], 32'h3002);
        chk("R4 size 16", 32'(log_size[3]), 32'd1);
        rd(5'h00, d); chk("R6 both done act back to 0", d & 32'h7F, 32'h0000_002A);
        chk("R8 no irq when ie=0", 32'(irq), 32'd0);
        dev_req = 1'b0;
        stop_and_clear();
    endtask

    task automatic t_zero_count();
        logic [31:0] d;
        wr(5'h0C, 32'h4000); wr(5'h10, 32'd0);
        wr(5'h00, 32'h0000_0001);
        dev_req = 1'b1;
        wr(5'h00, 32'h0000_0020);
        idle(10);
        chk("R6 zero count no beat", 32'(nlog), 32'd0);
        rd(5'h00, d); chk("R6 zero count completes", d & 32'h7F, 32'h0000_0032);
        dev_req = 1'b0;
        stop_and_clear();
    endtask

    task automatic t_halt_inflight();
        logic [31:0] d;
        wr(5'h0C, 32'h5000); wr(5'h10, 32'd2);
        wr(5'h00, 32'h0000_0001);
        dev_req = 1'b0; mem_ready = 1'b0;
        wr(5'h00, 32'h0000_0020);
        idle(10);
        chk("R4 no beat without request", 32'(mem_valid), 32'd0);
        dev_req = 1'b1;
        wait_mv();
        dev_req = 1'b0;
        wr(5'h04, 32'h0000_0020);
        idle(4);
        chk("R9 beat held while stopping", 32'(mem_valid), 32'd1);
        chk("R4 held addr", mem_addr, 32'h5000);
        rd(5'h00, d); chk("R9 not halted with beat in flight", d & 32'h40, 32'h0);
        mem_ready = 1'b1;
        idle(1);
        mem_ready = 1'b0;
        idle(3);
        chk("R9 one beat completed", 32'(nlog), 32'd1);
        chk("R9 no beat after halt", 32'(mem_valid), 32'd0);
        rd(5'h00, d); chk("R9 halted after beat", d & 32'h40, 32'h40);
        rd(5'h10, d); chk("R5 residual count", d, 32'd1);
        rd(5'h0C, d); chk("R5 step 1 for 8-bit", d, 32'h5001);
        mem_ready = 1'b1;
        stop_and_clear();
    endtask

    task automatic t_lanes();
        wr(5'h0C, 32'h6000); wr(5'h10, 32'd1);
        wr(5'h00, 32'h0000_2401);
        dev_rdata = 32'h1122_3344; mem_rdata = 32'hAABB_CCDD;
        mem_ready = 1'b0; dev_req = 1'b1;
        wr(5'h00, 32'h0000_0020);
        wait_mv();
        dev_req = 1'b0;
        chk("R11 32-bit reverse", mem_wdata, 32'h4433_2211);
        chk("R10 dir0 mem_we", 32'(mem_we), 32'd1);
        chk("R10 dir0 dev_we", 32'(dev_we), 32'd0);
        chk("R10 dir0 dev_wdata zero", dev_wdata, 32'h0);
        wr(5'h04, 32'h0000_2000);
        chk("R11 endian off passes", mem_wdata, 32'h1122_3344);
        wr(5'h04, 32'h0000_0600); wr(5'h00, 32'h0000_2200);
        chk("R11 16-bit swap", mem_wdata, 32'h1122_4433);
        wr(5'h04, 32'h0000_0600);
        chk("R11 8-bit unchanged", mem_wdata, 32'h1122_3344);
        wr(5'h00, 32'h0000_1000);
        chk("R10 dir1 dev_wdata", dev_wdata, 32'hAABB_CCDD);
        chk("R10 dir1 mem_we", 32'(mem_we), 32'd0);
        chk("R10 dir1 dev_we", 32'(dev_we), 32'd1);
        wr(5'h00, 32'h0000_0400);
        chk("R11 dir1 32-bit reverse", dev_wdata, 32'hDDCC_BBAA);
        chk("R10 dir1 mem_wdata zero", mem_wdata, 32'h0);
        mem_ready = 1'b1;
        idle(5);
        stop_and_clear();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_regs();
        t_single32();
        t_pingpong16();
        t_zero_count();
        t_halt_inflight();
        t_lanes();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done_flag) begin
            done_flag = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule